// File: doc/BRIEF.md
# Open-Bus Register Read Multiplexer

This block forms the byte returned to the processor on every memory-mapped I/O read. Many registers leave some bit positions undriven, and many addresses have no register at all. Real hardware does not return zeros in those positions. It returns whatever charge the bus still holds from an earlier transfer. The block models this with three retained bytes. The main-bus latch holds the last byte returned by any completed read. Two video-side latches each hold the last byte that one of the two video chips drove.

For each register, a fixed set of bit positions comes from the register logic. The remaining positions are filled from the latch that belongs to the bus segment the register sits on. The block also owns three two-state phase machines. Each one selects the low or high byte of a 16-bit quantity read through one 8-bit port. The block emits two strobes: one to latch the beam counters and one to acknowledge the timer interrupt flag. The register contents and the video pipeline are supplied from outside.

Each phase machine has two states, `PH_LO` and `PH_HI`. There are three transitions:
- `ADVANCE`: a completed read of the machine's own port flips the state.
- `CLEAR`: for the two counter machines, a completed read of the video status port forces the state to `PH_LO`.
- `HOLD`: in every other cycle the state stays as it is.

The palette machine has no `CLEAR` transition.

Top module: `obus_read_mux`

## Requirements
- R1: After reset all three latches are 0x00 and all phase machines are in `PH_LO`, so an unmapped read returns 0x00.
- R2: Every cycle with `rd_stb` high loads the main latch with the byte on `rd_data`. With `ext_sel` high, `rd_data` equals `ext_data`. An address that matches none of the registers in R3 to R11 returns the main latch unchanged. With `rd_stb` low, no latch or phase changes.
- R3: At 0x4016, bits 1:0 come from `reg_byte` and bits 7:2 from the main latch. At 0x4017, bits 4:0 read 1 and bits 7:5 come from the main latch.
- R4: At 0x4210, bits 7 and 3:0 come from `reg_byte` and bits 6:4 from the main latch. At 0x4212, bits 7:6 and 0 come from `reg_byte` and bits 5:1 from the main latch. 0x4213 is unmapped.
- R5: At 0x4211, bit 7 is `irq_flag` and bits 6:0 come from the main latch. A completed read pulses `irq_clear` in the same cycle.
- R6: At 0x2137 the read returns the main latch. A completed read pulses `cnt_latch` only when `io_ctl_b7` is 1.
- R7: Reads of 0x2134 to 0x2136 and 0x2138 to 0x213A return `reg_byte`. A read of 0x213E returns `reg_byte` with bit 4 taken from the main latch. All of these completed reads load video latch 1 (`vid1_obus`) with the returned byte.
- R8: The palette port 0x213B returns `pal_word[7:0]` in `PH_LO`. In `PH_HI` it returns `{video latch 2 bit 7, pal_word[14:8]}`. Each completed read toggles the palette phase.
- R9: Ports 0x213C and 0x213D return bits 7:0 of `hcnt` or `vcnt` in `PH_LO`. In `PH_HI` they return `{video latch 2 bits 7:1, counter bit 8}`. Each completed read toggles that port's own phase.
- R10: Port 0x213F returns `reg_byte` with bit 5 taken from video latch 2. A completed read returns both counter phases to `PH_LO`.
- R11: Completed reads of 0x213B, 0x213C, 0x213D and 0x213F load video latch 2 (`vid2_obus`) with the returned byte.
- R12: Addresses 0x2140 to 0x217F return mailbox byte `mbox_data[8*a+7:8*a]`, where a is address bits 1:0. Addresses 0x4214 to 0x421F and 0x4300 to 0x437F return `reg_byte` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_stb | input | 1 | A read completes at this clock edge |
| rd_addr | input | 16 | Register address of the read |
| ext_sel | input | 1 | Read is served by the external bus, not by a register |
| ext_data | input | 8 | External bus byte |
| reg_byte | input | 8 | Driven value of the addressed register |
| mbox_data | input | 32 | Four audio mailbox bytes, port 0 in bits 7:0 |
| pal_word | input | 16 | Addressed palette entry |
| hcnt | input | 9 | Latched horizontal counter |
| vcnt | input | 9 | Latched vertical counter |
| irq_flag | input | 1 | Timer interrupt flag |
| io_ctl_b7 | input | 1 | Counter-latch enable bit of the I/O control register |
| rd_data | output | 8 | Returned read byte |
| cnt_latch | output | 1 | Pulse: latch the beam counters |
| irq_clear | output | 1 | Pulse: clear the timer interrupt flag |
| vid1_obus | output | 8 | Video latch 1 |
| vid2_obus | output | 8 | Video latch 2 |

## Verification
The hard case is a read that both consumes a latch and reloads it in the same cycle. A `PH_HI` read of the palette or counter ports takes its upper bits from video latch 2 while that same read writes the result back into both video latch 2 and the main latch. The bench provokes this by reading these ports back to back, interleaved with status reads, through a full sweep of all 65,536 addresses. A bench-side model predicts each byte from the value each latch held before the edge and the value it holds after the edge, and compares both.

// File: rtl/obus_pkg.sv
package obus_pkg;
    localparam int DW = 8;
    localparam int AW = 16;
    localparam int NPH = 3;
    localparam int PH_PAL = 0;
    localparam int PH_HC  = 1;
    localparam int PH_VC  = 2;

    typedef enum logic {PH_LO = 1'b0, PH_HI = 1'b1} ph_t;

    typedef enum logic [4:0] {
        C_UNMAP, C_EXT, C_VID1, C_CNTL, C_PAL, C_HCNT, C_VCNT,
        C_STAT1, C_STAT2, C_MBOX, C_JOY0, C_JOY1, C_NMI, C_IRQ,
        C_HVB, C_DIRECT
    } cls_t;
endpackage

// File: rtl/obus_addr_decode.sv
module obus_addr_decode
    import obus_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic          ext_sel,
    output cls_t          cls
);
    always_comb begin
        cls = C_UNMAP;
        if (ext_sel) begin
            cls = C_EXT;
        end else if ((addr & 16'hFFC0) == 16'h2140) begin
            cls = C_MBOX;
        end else if ((addr & 16'hFF80) == 16'h4300) begin
            cls = C_DIRECT;
        end else if (addr >= 16'h4214 && addr <= 16'h421F) begin
            cls = C_DIRECT;
        end else begin
            unique case (addr)
                16'h2134, 16'h2135, 16'h2136,
                16'h2138, 16'h2139, 16'h213A: cls = C_VID1;
                16'h2137: cls = C_CNTL;
                16'h213B: cls = C_PAL;
                16'h213C: cls = C_HCNT;
                16'h213D: cls = C_VCNT;
                16'h213E: cls = C_STAT1;
                16'h213F: cls = C_STAT2;
                16'h4016: cls = C_JOY0;
                16'h4017: cls = C_JOY1;
                16'h4210: cls = C_NMI;
                16'h4211: cls = C_IRQ;
                16'h4212: cls = C_HVB;
                default:  cls = C_UNMAP;
            endcase
        end
    end
endmodule

// File: rtl/obus_phase_fsm.sv
module obus_phase_fsm
    import obus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic clr,
    output logic hi
);
    ph_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_LO;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PH_LO: if (adv) state_nx = PH_HI;
            PH_HI: if (clr || adv) state_nx = PH_LO;
            default: state_nx = PH_LO;
        endcase
        if (clr) state_nx = PH_LO;
    end

    always_comb hi = (state == PH_HI);

    assert_phase_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr) |=> (state != $past(state)));
    assert_phase_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state == PH_LO));
    assert_phase_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(state));
endmodule

// File: rtl/obus_latch_bank.sv
module obus_latch_bank
    import obus_pkg::*;
#(
    parameter int N = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  ld,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] q [N]
);
    for (genvar g = 0; g < N; g++) begin : g_lat
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q[g] <= '0;
            else if (ld[g]) q[g] <= din;
        end
        assert_latch_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ld[g] |=> (q[g] == $past(din)));
        assert_latch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !ld[g] |=> $stable(q[g]));
    end
endmodule

// File: rtl/obus_read_mux.sv
module obus_read_mux
    import obus_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_stb,
    input  logic [15:0] rd_addr,
    input  logic        ext_sel,
    input  logic [7:0]  ext_data,
    input  logic [7:0]  reg_byte,
    input  logic [31:0] mbox_data,
    input  logic [15:0] pal_word,
    input  logic [8:0]  hcnt,
    input  logic [8:0]  vcnt,
    input  logic        irq_flag,
    input  logic        io_ctl_b7,
    output logic [7:0]  rd_data,
    output logic        cnt_latch,
    output logic        irq_clear,
    output logic [7:0]  vid1_obus,
    output logic [7:0]  vid2_obus
);
    localparam int NL = 3;
    localparam int L_MAIN = 0;
    localparam int L_V1 = 1;
    localparam int L_V2 = 2;

    cls_t           cls;
    logic [NPH-1:0] ph_adv, ph_clr, ph_hi;
    logic [NL-1:0]  lat_ld;
    logic [DW-1:0]  lat_q [NL];
    logic [DW-1:0]  m_q, v2_q;

    obus_addr_decode u_dec (.addr(rd_addr), .ext_sel(ext_sel), .cls(cls));

    always_comb begin
        ph_adv = '0;
        ph_clr = '0;
        ph_adv[PH_PAL] = rd_stb && (cls == C_PAL);
        ph_adv[PH_HC]  = rd_stb && (cls == C_HCNT);
        ph_adv[PH_VC]  = rd_stb && (cls == C_VCNT);
        ph_clr[PH_HC]  = rd_stb && (cls == C_STAT2);
        ph_clr[PH_VC]  = rd_stb && (cls == C_STAT2);
    end

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        obus_phase_fsm u_ph (
            .clk(clk), .rst_n(rst_n),
            .adv(ph_adv[p]), .clr(ph_clr[p]), .hi(ph_hi[p])
        );
    end

    always_comb begin
        lat_ld = '0;
        lat_ld[L_MAIN] = rd_stb;
        lat_ld[L_V1]   = rd_stb && (cls == C_VID1 || cls == C_STAT1);
        lat_ld[L_V2]   = rd_stb && (cls == C_PAL || cls == C_HCNT ||
                                    cls == C_VCNT || cls == C_STAT2);
    end

    obus_latch_bank #(.N(NL)) u_lat (
        .clk(clk), .rst_n(rst_n), .ld(lat_ld), .din(rd_data), .q(lat_q)
    );

    always_comb begin
        m_q  = lat_q[L_MAIN];
        v2_q = lat_q[L_V2];
        vid1_obus = lat_q[L_V1];
        vid2_obus = lat_q[L_V2];
    end

    always_comb begin
        rd_data = m_q;
        unique case (cls)
            C_EXT:    rd_data = ext_data;
            C_VID1:   rd_data = reg_byte;
            C_CNTL:   rd_data = m_q;
            C_PAL:    rd_data = ph_hi[PH_PAL] ? {v2_q[7], pal_word[14:8]} : pal_word[7:0];
            C_HCNT:   rd_data = ph_hi[PH_HC] ? {v2_q[7:1], hcnt[8]} : hcnt[7:0];
            C_VCNT:   rd_data = ph_hi[PH_VC] ? {v2_q[7:1], vcnt[8]} : vcnt[7:0];
            C_STAT1:  rd_data = {reg_byte[7:5], m_q[4], reg_byte[3:0]};
            C_STAT2:  rd_data = {reg_byte[7:6], v2_q[5], reg_byte[4:0]};
            C_MBOX:   rd_data = mbox_data[8*rd_addr[1:0] +: 8];
            C_JOY0:   rd_data = {m_q[7:2], reg_byte[1:0]};
            C_JOY1:   rd_data = {m_q[7:5], 5'h1F};
            C_NMI:    rd_data = (reg_byte & 8'h8F) | (m_q & 8'h70);
            C_IRQ:    rd_data = {irq_flag, m_q[6:0]};
            C_HVB:    rd_data = (reg_byte & 8'hC1) | (m_q & 8'h3E);
            C_DIRECT: rd_data = reg_byte;
            C_UNMAP:  rd_data = m_q;
            default:  rd_data = m_q;
        endcase
    end

    always_comb begin
        cnt_latch = rd_stb && (cls == C_CNTL) && io_ctl_b7;
        irq_clear = rd_stb && (cls == C_IRQ);
    end

    assert_unmapped_main_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_sel && rd_addr == 16'h4213) |-> (rd_data == vid_main_chk()));
    assert_cntlatch_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_latch |-> (io_ctl_b7 && rd_stb && rd_addr == 16'h2137 && !ext_sel));
    assert_irqclr_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clear |-> (rd_stb && rd_addr == 16'h4211 && !ext_sel));
    assert_joy1_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_sel && rd_addr == 16'h4017) |-> (rd_data[4:0] == 5'h1F));

    function automatic logic [7:0] vid_main_chk();
        return lat_q[L_MAIN];
    endfunction
endmodule

// File: tb/obus_read_mux_tb.sv
module obus_read_mux_tb;
    localparam int CLK_PER = 10;

    logic        clk = 0, rst_n = 0, rd_stb = 0, ext_sel = 0, irq_flag = 0, io_ctl_b7 = 0;
    logic [15:0] rd_addr = 0, pal_word = 0;
    logic [7:0]  ext_data = 0, reg_byte = 0;
    logic [31:0] mbox_data = 32'h0;
    logic [8:0]  hcnt = 0, vcnt = 0;
    logic [7:0]  rd_data, vid1_obus, vid2_obus;
    logic        cnt_latch, irq_clear;

    int n_chk = 0, n_fail = 0;
    logic [7:0] m_m = 0, m_v1 = 0, m_v2 = 0;
    logic p_pal = 0, p_h = 0, p_v = 0;

    always #(CLK_PER/2) clk = ~clk;

    obus_read_mux u_dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, rd_addr, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [15:0] a, input logic e);
        if (e) return "R2";
        if (a >= 16'h2140 && a <= 16'h217F) return "R12";
        if ((a >= 16'h4300 && a <= 16'h437F) || (a >= 16'h4214 && a <= 16'h421F)) return "R12";
        case (a)
            16'h2134, 16'h2135, 16'h2136, 16'h2138, 16'h2139, 16'h213A, 16'h213E: return "R7";
            16'h2137: return "R6";
            16'h213B: return "R8";
            16'h213C, 16'h213D: return "R9";
            16'h213F: return "R10";
            16'h4016, 16'h4017: return "R3";
            16'h4210, 16'h4212: return "R4";
            16'h4211: return "R5";
            default: return "R2";
        endcase
    endfunction

    function automatic logic [7:0] exp_byte(input logic [15:0] a);
        if (ext_sel) return ext_data;
        if (a >= 16'h2140 && a <= 16'h217F) return mbox_data[8*a[1:0] +: 8];
        if ((a >= 16'h4300 && a <= 16'h437F) || (a >= 16'h4214 && a <= 16'h421F)) return reg_byte;
        case (a)
            16'h2134, 16'h2135, 16'h2136, 16'h2138, 16'h2139, 16'h213A: return reg_byte;
            16'h213B: return p_pal ? {m_v2[7], pal_word[14:8]} : pal_word[7:0];
            16'h213C: return p_h ? {m_v2[7:1], hcnt[8]} : hcnt[7:0];
            16'h213D: return p_v ? {m_v2[7:1], vcnt[8]} : vcnt[7:0];
            16'h213E: return {reg_byte[7:5], m_m[4], reg_byte[3:0]};
            16'h213F: return {reg_byte[7:6], m_v2[5], reg_byte[4:0]};
            16'h4016: return {m_m[7:2], reg_byte[1:0]};
            16'h4017: return {m_m[7:5], 5'b11111};
            16'h4210: return {reg_byte[7], m_m[6:4], reg_byte[3:0]};
            16'h4211: return {irq_flag, m_m[6:0]};
            16'h4212: return {reg_byte[7:6], m_m[5:1], reg_byte[0]};
            default:  return m_m;
        endcase
    endfunction

    task automatic rd(input logic [15:0] a, input logic e, input logic [7:0] rb, input int seed);
        logic [7:0] x;
        string t;
        @(negedge clk);
        rd_stb = 1; rd_addr = a; ext_sel = e; reg_byte = rb;
        ext_data = rb ^ 8'hC3;
        mbox_data = {rb, ~rb, rb + 8'd17, rb ^ 8'h99};
        pal_word = {rb ^ 8'h5A, ~rb};
        hcnt = {rb[0], rb ^ 8'h33};
        vcnt = {rb[1], rb ^ 8'hCC};
        irq_flag = seed[2];
        io_ctl_b7 = seed[4];
        #1;
        t = tag_of(a, e);
        x = exp_byte(a);
        chk(t, rd_data, x);
        chk("R6", cnt_latch, (!e && a == 16'h2137 && io_ctl_b7));
        chk("R5", irq_clear, (!e && a == 16'h4211));
        @(posedge clk);
        m_m = x;
        if (!e) begin
            case (a)
                16'h2134, 16'h2135, 16'h2136, 16'h2138, 16'h2139, 16'h213A, 16'h213E: m_v1 = x;
                16'h213B: begin m_v2 = x; p_pal = ~p_pal; end
                16'h213C: begin m_v2 = x; p_h = ~p_h; end
                16'h213D: begin m_v2 = x; p_v = ~p_v; end
                16'h213F: begin m_v2 = x; p_h = 0; p_v = 0; end
                default: ;
            endcase
        end
        #1;
        chk("R7", vid1_obus, m_v1);
        chk("R11", vid2_obus, m_v2);
    endtask

    initial begin
        #(CLK_PER * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] hold;
        repeat (3) @(posedge clk);
        rst_n = 1;
        @(negedge clk);
        rd_addr = 16'h0000;
        #1;
        chk("R1", rd_data, 8'h00);
        chk("R1", vid1_obus, 8'h00);
        chk("R1", vid2_obus, 8'h00);
        // R2: idle strobe leaves everything alone
        rd(16'h4016, 0, 8'hA7, 0);
        hold = rd_data;
        @(negedge clk); rd_stb = 0; rd_addr = 16'h2139; reg_byte = 8'h3C;
        @(negedge clk); rd_addr = 16'h0100; #1;
        chk("R2", rd_data, m_m);
        chk("R2", vid1_obus, m_v1);
        // R8, R9, R10: back-to-back phase reads interleaved with status reads
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            case (i % 6)
                0: a = 16'h213B;
                1: a = 16'h213C;
                2: a = 16'h213D;
                3: a = (i % 4 == 3) ? 16'h213F : 16'h213C;
                4: a = 16'h213E;
                default: a = 16'h213B;
            endcase
            rd(a, 0, 8'(i * 37 + 11), i);
        end
        // near-exhaustive address sweep
        for (int a = 0; a < 65536; a++) begin
            rd(16'(a), (a % 7) == 3, 8'(a[7:0] ^ a[15:8] ^ 8'h5A), a);
        end
        @(negedge clk); rd_stb = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule